// File: doc/BRIEF.md
# Message-Signaled Interrupt Capability Register File

This block holds the configuration registers of a basic message-signaled interrupt capability, with per-vector masking. Software reaches it through a DWORD-indexed configuration read/write port, where index 0 is the capability header at the capability pointer. A parameter selects one of two layouts. In the first, the message address is 32 bits wide. In the second, an upper-address register follows the address register, and every register after it moves up by one DWORD.

Each interrupt source has one request line. A request pulse latches the vector's pending bit. When messaging is enabled and the vector is not masked, the block presents a message-write request on its output: the programmed address, the message data and the vector number. The block holds that request until it is acknowledged, and the acknowledge clears the pending bit. A masked vector keeps its pending bit set and sends its message once software unmasks it.

Top module: `msi_cap_regs`

## Requirements
- R1: Header DWORD (index 0): bits 7:0 read 05h, bits 15:8 read the CAP_NEXT parameter (0 marks the last list item), bit 16 is the read/write enable flag (reset 0), bits 19:17 read ceil(log2(NUM_VEC)), bit 23 reads 1 only in the 64-bit layout, bit 24 reads 1 (masking supported), all other bits read 0. Writes to every bit other than bit 16 are ignored.
- R2: With ADDR64=0, DWORD index 1 is the address, 2 the data, 3 the mask and 4 the pending register (byte offsets 04h, 08h, 0Ch, 10h).
- R3: With ADDR64=1, DWORD index 1 is the address, 2 the upper address, 3 the data, 4 the mask and 5 the pending register (byte offsets 04h to 14h).
- R4: Address bits 1:0 and data bits 31:16 read 0. Mask bits at or above NUM_VEC read 0. An index that has no register reads 0, and a write to it has no effect.
- R5: The pending register is read-only: a write to it leaves the pending bits unchanged.
- R6: A request on an unmasked vector while enabled produces a message with msg_addr = {upper address (0 in the 32-bit layout), address}, msg_data = {16'h0, data} and msg_vec = the vector index.
- R7: A request on a masked vector sends nothing and sets pending bit n of the pending register. Clearing the mask bit then sends the message, and the pending bit clears once the message is acknowledged.
- R8: While the enable bit is 0, no message is issued. Requests are kept as pending bits and are sent after the enable bit is set.
- R9: When several vectors are ready at once, the messages go out one at a time, lowest vector index first.
- R10: msg_valid and the message fields stay stable until msg_ack. The cycle after the acknowledge, msg_valid is low.
- R11: Requests that repeat while a vector is already pending merge into a single message.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_dw_off | input | 3 | DWORD index relative to the capability pointer |
| cfg_wdata | input | 32 | Write data |
| cfg_rdata | output | 32 | Read data for cfg_dw_off (combinational) |
| irq_req | input | NUM_VEC | Per-vector request pulses |
| msg_valid | output | 1 | Message-write request |
| msg_addr | output | 64 | Message address |
| msg_data | output | 32 | Message data DWORD |
| msg_vec | output | VEC_W | Vector index of the message |
| msg_ack | input | 1 | Message accepted |

## Verification
The bench targets the layout shift. It places a second, 32-bit instance beside the 64-bit one, so that a design decoding the wrong map returns data where the mask or pending register should be. It masks vectors, raises requests, reads the pending register back and tries to write it. A design that sent a masked message, lost the deferred request, or let software clear pending bits would show up as an unexpected message, a missing message or a wrong pending value. Simultaneous requests, repeated requests while pending, and requests while disabled expose wrong ordering, duplicate messages and sends that should have been held back.

// File: rtl/msi_cap_pkg.sv
package msi_cap_pkg;

   localparam int        DW_OFF_W = 3;
   localparam logic [7:0] CAP_ID  = 8'h05;

   typedef enum logic [2:0] {
      REG_HDR,
      REG_ADDR,
      REG_UPPER,
      REG_DATA,
      REG_MASK,
      REG_PEND,
      REG_NONE
   } msi_reg_e;

   // map a DWORD index onto a register; the 64-bit layout inserts the upper address
   function automatic msi_reg_e decode_off(logic [DW_OFF_W-1:0] off, bit a64);
      msi_reg_e r;
      r = REG_NONE;
      if (a64) begin
         case (off)
            3'd0: r = REG_HDR;
            3'd1: r = REG_ADDR;
            3'd2: r = REG_UPPER;
            3'd3: r = REG_DATA;
            3'd4: r = REG_MASK;
            3'd5: r = REG_PEND;
            default: r = REG_NONE;
         endcase
      end else begin
         case (off)
            3'd0: r = REG_HDR;
            3'd1: r = REG_ADDR;
            3'd2: r = REG_DATA;
            3'd3: r = REG_MASK;
            3'd4: r = REG_PEND;
            default: r = REG_NONE;
         endcase
      end
      return r;
   endfunction

endpackage

// File: rtl/msi_cap_regfile.sv
module msi_cap_regfile
   import msi_cap_pkg::*;
#(
   parameter int         NUM_VEC  = 8,
   parameter bit         ADDR64   = 1'b1,
   parameter logic [7:0] CAP_NEXT = 8'h00
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [DW_OFF_W-1:0] cfg_dw_off,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic [NUM_VEC-1:0]  pend_bits,
   output logic                msi_en,
   output logic [NUM_VEC-1:0]  mask_bits,
   output logic [63:0]         cur_addr,
   output logic [31:0]         cur_data
);
   localparam int         MMC_V = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 0;
   localparam logic [2:0] MMC   = MMC_V[2:0];

   msi_reg_e     sel;
   logic         en_q;
   logic [31:2]  addr_q;
   logic [15:0]  data_q;
   logic [NUM_VEC-1:0] mask_q;
   logic [31:0]  upper;

   assign sel = decode_off(cfg_dw_off, ADDR64);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         en_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
         mask_q <= '0;
      end else if (cfg_wr) begin
         case (sel)
            REG_HDR:  en_q   <= cfg_wdata[16];
            REG_ADDR: addr_q <= cfg_wdata[31:2];
            REG_DATA: data_q <= cfg_wdata[15:0];
            REG_MASK: mask_q <= cfg_wdata[NUM_VEC-1:0];
            default: ;
         endcase
      end
   end

   generate
      if (ADDR64) begin : g_upper
         logic [31:0] upper_q;
         always_ff @(posedge clk) begin
            if (!rst_n)
               upper_q <= '0;
            else if (cfg_wr && sel == REG_UPPER)
               upper_q <= cfg_wdata;
         end
         assign upper = upper_q;
      end else begin : g_no_upper
         assign upper = '0;
      end
   endgenerate

   always_comb begin
      cfg_rdata = '0;
      case (sel)
         REG_HDR: begin
            cfg_rdata[7:0]   = CAP_ID;
            cfg_rdata[15:8]  = CAP_NEXT;
            cfg_rdata[16]    = en_q;
            cfg_rdata[19:17] = MMC;
            cfg_rdata[23]    = ADDR64;
            cfg_rdata[24]    = 1'b1;
         end
         REG_ADDR:  cfg_rdata[31:2]        = addr_q;
         REG_UPPER: cfg_rdata              = upper;
         REG_DATA:  cfg_rdata[15:0]        = data_q;
         REG_MASK:  cfg_rdata[NUM_VEC-1:0] = mask_q;
         REG_PEND:  cfg_rdata[NUM_VEC-1:0] = pend_bits;
         default:   cfg_rdata              = '0;
      endcase
   end

   assign msi_en    = en_q;
   assign mask_bits = mask_q;
   assign cur_addr  = {upper, addr_q, 2'b00};
   assign cur_data  = {16'h0000, data_q};

endmodule

// File: rtl/msi_cap_pending.sv
module msi_cap_pending #(
   parameter int NUM_VEC = 8,
   parameter int VEC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] irq_req,
   input  logic               clr_vld,
   input  logic [VEC_W-1:0]   clr_idx,
   output logic [NUM_VEC-1:0] pend_bits
);
   generate
      for (genvar v = 0; v < NUM_VEC; v++) begin : g_bit
         logic hit;
         assign hit = clr_vld && (clr_idx == v[VEC_W-1:0]);
         always_ff @(posedge clk) begin
            if (!rst_n)
               pend_bits[v] <= 1'b0;
            else if (irq_req[v])
               pend_bits[v] <= 1'b1;   // a new request outranks a clear in the same cycle
            else if (hit)
               pend_bits[v] <= 1'b0;
         end
      end
   endgenerate
endmodule

// File: rtl/msi_cap_msgout.sv
module msi_cap_msgout #(
   parameter int NUM_VEC = 8,
   parameter int VEC_W   = 3
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_VEC-1:0] ready_vec,
   input  logic [63:0]        cur_addr,
   input  logic [31:0]        cur_data,
   input  logic               msg_ack,
   output logic               msg_valid,
   output logic [63:0]        msg_addr,
   output logic [31:0]        msg_data,
   output logic [VEC_W-1:0]   msg_vec,
   output logic               clr_vld,
   output logic [VEC_W-1:0]   clr_idx
);
   logic [VEC_W-1:0] pick;
   logic             any;

   // lowest ready index wins
   always_comb begin
      pick = '0;
      for (int i = NUM_VEC - 1; i >= 0; i--)
         if (ready_vec[i]) pick = i[VEC_W-1:0];
   end
   assign any = |ready_vec;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         msg_valid <= 1'b0;
         msg_addr  <= '0;
         msg_data  <= '0;
         msg_vec   <= '0;
      end else if (msg_valid) begin
         if (msg_ack) msg_valid <= 1'b0;
      end else if (any) begin
         msg_valid <= 1'b1;
         msg_addr  <= cur_addr;
         msg_data  <= cur_data;
         msg_vec   <= pick;
      end
   end

   assign clr_vld = msg_valid && msg_ack;
   assign clr_idx = msg_vec;
endmodule

// File: rtl/msi_cap_regs.sv
module msi_cap_regs
   import msi_cap_pkg::*;
#(
   parameter int         NUM_VEC  = 8,
   parameter bit         ADDR64   = 1'b1,
   parameter logic [7:0] CAP_NEXT = 8'h00,
   localparam int        VEC_W    = (NUM_VEC > 1) ? $clog2(NUM_VEC) : 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_wr,
   input  logic [DW_OFF_W-1:0] cfg_dw_off,
   input  logic [31:0]         cfg_wdata,
   output logic [31:0]         cfg_rdata,
   input  logic [NUM_VEC-1:0]  irq_req,
   output logic                msg_valid,
   output logic [63:0]         msg_addr,
   output logic [31:0]         msg_data,
   output logic [VEC_W-1:0]    msg_vec,
   input  logic                msg_ack
);
   generate
      if (NUM_VEC < 1 || NUM_VEC > 32) begin : g_bad_num_vec
         $error("msi_cap_regs: NUM_VEC must lie in 1..32");
      end
   endgenerate

   logic               msi_en;
   logic [NUM_VEC-1:0] mask_bits;
   logic [NUM_VEC-1:0] pend_bits;
   logic [NUM_VEC-1:0] ready_vec;
   logic [63:0]        cur_addr;
   logic [31:0]        cur_data;
   logic               clr_vld;
   logic [VEC_W-1:0]   clr_idx;

   msi_cap_regfile #(.NUM_VEC(NUM_VEC), .ADDR64(ADDR64), .CAP_NEXT(CAP_NEXT)) u_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_off(cfg_dw_off),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .pend_bits(pend_bits),
      .msi_en(msi_en), .mask_bits(mask_bits), .cur_addr(cur_addr), .cur_data(cur_data)
   );

   msi_cap_pending #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_pend (
      .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .clr_vld(clr_vld),
      .clr_idx(clr_idx), .pend_bits(pend_bits)
   );

   assign ready_vec = pend_bits & ~mask_bits & {NUM_VEC{msi_en}};

   msi_cap_msgout #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_out (
      .clk(clk), .rst_n(rst_n), .ready_vec(ready_vec), .cur_addr(cur_addr),
      .cur_data(cur_data), .msg_ack(msg_ack), .msg_valid(msg_valid),
      .msg_addr(msg_addr), .msg_data(msg_data), .msg_vec(msg_vec),
      .clr_vld(clr_vld), .clr_idx(clr_idx)
   );
endmodule

// File: rtl/msi_cap_checker.sv
module msi_cap_checker #(
   parameter int NUM_VEC = 8,
   parameter int VEC_W   = 3
) (
   input logic               clk,
   input logic               rst_n,
   input logic [NUM_VEC-1:0] irq_req,
   input logic               msg_valid,
   input logic               msg_ack,
   input logic [63:0]        msg_addr,
   input logic [31:0]        msg_data,
   input logic [VEC_W-1:0]   msg_vec,
   input logic [NUM_VEC-1:0] pend_bits,
   input logic [NUM_VEC-1:0] mask_bits,
   input logic               msi_en
);
   assert_hold_until_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && !msg_ack |=> msg_valid && $stable(msg_addr) && $stable(msg_data) && $stable(msg_vec));

   assert_drop_after_ack_R10: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ack |=> !msg_valid);

   assert_no_send_disabled_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> $past(msi_en));

   assert_no_send_masked_R7: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(msg_valid) |-> ((($past(mask_bits) >> msg_vec) & 1) == 0));

   assert_sent_is_pending_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid |-> pend_bits[msg_vec]);

   assert_request_latched_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_req != '0) |=> ((pend_bits & $past(irq_req)) == $past(irq_req)));

   assert_ack_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
      msg_valid && msg_ack && !irq_req[msg_vec] |=> !pend_bits[$past(msg_vec)]);
endmodule

bind msi_cap_regs msi_cap_checker #(.NUM_VEC(NUM_VEC), .VEC_W(VEC_W)) u_chk (.*);

// File: tb/test_msi_cap_regs.sv
module test_msi_cap_regs;
   localparam int CLK_PERIOD = 10;
   localparam int NV = 8;
   localparam int VW = 3;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cfg_wr = 1'b0;
   logic [2:0] cfg_dw_off = '0;
   logic [31:0] cfg_wdata = '0;
   logic [31:0] cfg_rdata;
   logic [NV-1:0] irq_req = '0;
   logic msg_valid;
   logic [63:0] msg_addr;
   logic [31:0] msg_data;
   logic [VW-1:0] msg_vec;
   logic msg_ack = 1'b0;

   // second instance: 32-bit layout, register port only
   logic cfg_wr_b = 1'b0;
   logic [2:0] off_b = '0;
   logic [31:0] wdata_b = '0;
   logic [31:0] rdata_b;
   logic valid_b;
   logic [63:0] addr_b;
   logic [31:0] data_b;
   logic [4:0] vec_b;

   int n_chk = 0;
   int n_fail = 0;

   typedef struct packed { logic [VW-1:0] vec; logic [63:0] addr; logic [31:0] data; } exp_t;
   exp_t exp_q[$];

   always #(CLK_PERIOD/2) clk = ~clk;

   msi_cap_regs #(.NUM_VEC(NV), .ADDR64(1'b1), .CAP_NEXT(8'h60)) i_msi_cap_regs (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_dw_off(cfg_dw_off),
      .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .irq_req(irq_req),
      .msg_valid(msg_valid), .msg_addr(msg_addr), .msg_data(msg_data),
      .msg_vec(msg_vec), .msg_ack(msg_ack)
   );

   msi_cap_regs #(.NUM_VEC(32), .ADDR64(1'b0), .CAP_NEXT(8'h00)) i_msi_cap_regs_32 (
      .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr_b), .cfg_dw_off(off_b),
      .cfg_wdata(wdata_b), .cfg_rdata(rdata_b), .irq_req(32'h0),
      .msg_valid(valid_b), .msg_addr(addr_b), .msg_data(data_b),
      .msg_vec(vec_b), .msg_ack(1'b0)
   );

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] off, input logic [31:0] d);
      @(negedge clk);
      cfg_wr = 1'b1; cfg_dw_off = off; cfg_wdata = d;
      @(negedge clk);
      cfg_wr = 1'b0;
   endtask

   task automatic rd(input logic [2:0] off, output logic [31:0] d);
      cfg_dw_off = off;
      #1;
      d = cfg_rdata;
   endtask

   task automatic wr_b(input logic [2:0] off, input logic [31:0] d);
      @(negedge clk);
      cfg_wr_b = 1'b1; off_b = off; wdata_b = d;
      @(negedge clk);
      cfg_wr_b = 1'b0;
   endtask

   task automatic rd_b(input logic [2:0] off, output logic [31:0] d);
      off_b = off;
      #1;
      d = rdata_b;
   endtask

   task automatic pulse(input logic [NV-1:0] v);
      @(negedge clk);
      irq_req = v;
      @(negedge clk);
      irq_req = '0;
   endtask

   task automatic expect_msg(input int v);
      exp_t e;
      e.vec  = v[VW-1:0];
      e.addr = 64'h0000_0001_FEE0_1234;
      e.data = 32'h0000_4321;
      exp_q.push_back(e);
   endtask

   task automatic settle();
      repeat (8) @(negedge clk);
   endtask

   // monitor: compare each message with the queue head and acknowledge it
   always @(negedge clk) begin
      if (rst_n) begin
         if (msg_ack) begin
            msg_ack = 1'b0;
            chk("R10 valid low after ack", {63'h0, msg_valid}, 64'h0);
         end else if (msg_valid) begin
            if (exp_q.size() == 0) begin
               chk("R7/R8/R11 unexpected message, vector", {61'h0, msg_vec}, 64'hFFFF);
            end else begin
               exp_t e;
               e = exp_q.pop_front();
               chk("R9 vector order", {61'h0, msg_vec}, {61'h0, e.vec});
               chk("R6 address", msg_addr, e.addr);
               chk("R6 data", {32'h0, msg_data}, {32'h0, e.data});
            end
            msg_ack = 1'b1;
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      logic [31:0] d;
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset header and read-only fields
      rd(3'd0, d); chk("R1 header reset", {32'h0, d}, 64'h0186_6005);
      wr(3'd0, 32'hFFFF_FFFF);
      rd(3'd0, d); chk("R1 header after write", {32'h0, d}, 64'h0187_6005);

      // R3 64-bit layout, R4 reserved bits
      wr(3'd1, 32'hFEE0_1237);
      wr(3'd2, 32'h0000_0001);
      wr(3'd3, 32'hABCD_4321);
      rd(3'd1, d); chk("R3/R4 address", {32'h0, d}, 64'hFEE0_1234);
      rd(3'd2, d); chk("R3 upper address", {32'h0, d}, 64'h1);
      rd(3'd3, d); chk("R3/R4 data", {32'h0, d}, 64'h4321);
      wr(3'd4, 32'h0000_FFFF);
      rd(3'd4, d); chk("R3/R4 mask width", {32'h0, d}, 64'hFF);
      wr(3'd4, 32'h0);
      wr(3'd6, 32'hFFFF_FFFF);
      rd(3'd6, d); chk("R4 unused index", {32'h0, d}, 64'h0);
      rd(3'd7, d); chk("R4 unused index", {32'h0, d}, 64'h0);
      rd(3'd1, d); chk("R4 no side effect", {32'h0, d}, 64'hFEE0_1234);

      // R6 plain delivery
      expect_msg(0); pulse(8'h01); settle();
      expect_msg(7); pulse(8'h80); settle();
      rd(3'd5, d); chk("R6 pending clear", {32'h0, d}, 64'h0);

      // R7 masked vector, R5 pending read-only
      wr(3'd4, 32'h04);
      pulse(8'h04); settle();
      rd(3'd5, d); chk("R7 pending set", {32'h0, d}, 64'h04);
      wr(3'd5, 32'hFF);
      rd(3'd5, d); chk("R5 pending read-only", {32'h0, d}, 64'h04);
      wr(3'd5, 32'h00);
      rd(3'd5, d); chk("R5 pending read-only", {32'h0, d}, 64'h04);
      expect_msg(2);
      wr(3'd4, 32'h0); settle();
      rd(3'd5, d); chk("R7 pending cleared", {32'h0, d}, 64'h0);

      // R11 merge while pending
      wr(3'd4, 32'h08);
      pulse(8'h08); pulse(8'h08); pulse(8'h08); settle();
      rd(3'd5, d); chk("R11 one pending bit", {32'h0, d}, 64'h08);
      expect_msg(3);
      wr(3'd4, 32'h0); settle();

      // R8 disabled
      wr(3'd0, 32'h0);
      pulse(8'h02); settle();
      rd(3'd5, d); chk("R8 held pending", {32'h0, d}, 64'h02);
      expect_msg(1);
      wr(3'd0, 32'h0001_0000); settle();

      // R9 lowest first
      wr(3'd4, 32'hFF);
      pulse(8'h62); pulse(8'h10); settle();
      rd(3'd5, d); chk("R9 pending set", {32'h0, d}, 64'h72);
      expect_msg(1); expect_msg(4); expect_msg(5); expect_msg(6);
      wr(3'd4, 32'h0);
      repeat (20) @(negedge clk);
      chk("R9 all sent", {32'h0, exp_q.size()}, 64'h0);

      // R2 32-bit layout
      rd_b(3'd0, d); chk("R1/R2 header 32-bit", {32'h0, d}, 64'h010A_0000 | 64'h5);
      wr_b(3'd1, 32'h1234_5679);
      wr_b(3'd2, 32'hFFFF_BEEF);
      wr_b(3'd3, 32'hFFFF_FFFF);
      wr_b(3'd4, 32'hFFFF_FFFF);
      wr_b(3'd5, 32'hFFFF_FFFF);
      rd_b(3'd1, d); chk("R2 address", {32'h0, d}, 64'h1234_5678);
      rd_b(3'd2, d); chk("R2 data", {32'h0, d}, 64'hBEEF);
      rd_b(3'd3, d); chk("R2 mask", {32'h0, d}, 64'hFFFF_FFFF);
      rd_b(3'd4, d); chk("R2 pending", {32'h0, d}, 64'h0);
      rd_b(3'd5, d); chk("R2/R4 beyond map", {32'h0, d}, 64'h0);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule